// File: doc/BRIEF.md
# Frame-Transfer CCD Frame Sequencer

This block runs one frame of a frame-transfer area sensor that has an image zone, a masked memory zone of equal height and four parallel readout taps. A frame starts with one burst that moves the whole image zone into the memory zone. The memory zone is then read one line at a time, and that readout time is also the integration time of the next frame. The block does not make analog clocks. It asks a vertical phase generator for either a full image-to-memory burst or a single memory line shift, and it asks a line readout generator to read one register line. Both requests use a start pulse and a done pulse.

The antiblooming gate is held high (integrating) at all times except around the burst. It falls a guard time before the burst and rises a guard time after the burst. The shutter output tells the image clock drivers to hold the image gates in the draining state, so that photocharge goes to the antiblooming drain. Draining is applied during the early output lines of the readout. Only the last `exposure` output lines integrate. When `exposure` is equal to or larger than the number of output lines, the whole readout integrates. An optional cleaning pass shifts the memory zone as many times as it has lines before the burst, using the same shift request as readout, with no register readout. In binning mode, two memory shifts go into each register line, so a frame gives half as many output lines.

States:
- S_IDLE waits for `start`.
- The cleaning pass cycles S_CLEAN_REQ and S_CLEAN_WAIT, then ends in S_CLEAN_END.
- S_AB_FALL is the guard before the burst.
- The burst runs S_XFER_REQ, S_XFER_WAIT and S_XFER_END.
- S_AB_RISE is the guard after the burst.
- Each output line runs S_SHIFT_REQ and S_SHIFT_WAIT, once or twice, then S_LINE_REQ and S_LINE_WAIT.
- The frame closes with S_READ_END and then S_FRAME_END.

Transitions:
- IDLE to CLEAN_REQ when `start` arrives and cleaning is enabled; otherwise IDLE to AB_FALL.
- CLEAN_WAIT to CLEAN_REQ on `vert_done` until the last shift; on the last shift, CLEAN_WAIT to CLEAN_END.
- AB_FALL to XFER_REQ when the guard expires.
- XFER_WAIT to XFER_END on `vert_done`.
- AB_RISE to SHIFT_REQ when the guard expires.
- SHIFT_WAIT to SHIFT_REQ on `vert_done` when a second binned shift is still due; otherwise SHIFT_WAIT to LINE_REQ.
- LINE_WAIT to SHIFT_REQ on `line_done`; after the last output line, LINE_WAIT to READ_END.
- READ_END to FRAME_END, then FRAME_END to IDLE.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset, `busy`, `drain`, `vert_start`, `line_start` and all done pulses are 0, and `ab_gate` is 1.
- R2: Without cleaning, the first request of a frame is one `vert_start` with `vert_mode` = 2'b01 (image-to-memory burst). It is issued exactly once per frame, and `xfer_done` pulses after its `vert_done`.
- R3: `ab_gate` is 0 for exactly GUARD_CYC cycles before the cycle that carries the burst request. After the `xfer_done` cycle it stays 0 for exactly GUARD_CYC more cycles, then returns to 1.
- R4: With `clean_en` set at start, exactly LINES requests with `vert_mode` = 2'b10 (memory line shift) come before the burst, with no `line_start` among them. They are followed by one `clean_done` pulse.
- R5: In normal mode the readout issues LINES output lines. Each line is one shift request (2'b10) followed by one `line_start` with `line_bin` = 0.
- R6: In binning mode the readout issues LINES/2 output lines. Each line is two shift requests followed by one `line_start` with `line_bin` = 1.
- R7: With N output lines and exposure E, `drain` is 1 during output lines 0 to N-E-1 and 0 during the last E lines. When E >= N, `drain` stays 0 for the whole frame. `drain` is never 1 while `ab_gate` is 0.
- R8: `busy` is 1 from the cycle after an accepted start through the `frame_done` cycle. A `start` while busy is ignored and causes no extra request.
- R9: `clean_done`, `xfer_done`, `read_done` and `frame_done` are one-cycle pulses, issued in that order. `read_done` comes after the last `line_done`, and `frame_done` comes the cycle after `read_done`.
- R10: `vert_mode` is 2'b01 or 2'b10 whenever `vert_start` is 1. `ab_gate` is 1 whenever `line_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start-of-frame request, accepted only when idle |
| exposure | input | EXP_W | Integration length in output line periods, latched at start |
| bin_en | input | 1 | 2x2 binning for the frame, latched at start |
| clean_en | input | 1 | Cleaning pass before the burst, latched at start |
| vert_done | input | 1 | Vertical phase generator finished the request |
| line_done | input | 1 | Line readout generator finished the line |
| busy | output | 1 | Frame in progress |
| ab_gate | output | 1 | Antiblooming gate level (1 = integrate) |
| drain | output | 1 | Shutter: hold image gates in the draining state |
| vert_start | output | 1 | One-cycle request to the vertical phase generator |
| vert_mode | output | 2 | 01 = image-to-memory burst, 10 = single memory line shift |
| line_start | output | 1 | One-cycle request to read one register line |
| line_bin | output | 1 | Register line carries two summed lines and pixel pairs |
| clean_done | output | 1 | Cleaning pass finished |
| xfer_done | output | 1 | Burst finished |
| read_done | output | 1 | Last output line read |
| frame_done | output | 1 | Frame finished |

## Verification
The frame is run four ways:
- Plain, with an exposure larger than the frame. This separates the request sequence from shutter effects.
- With cleaning and a short exposure. This shows that the cleaning shifts come before the burst and that draining stops at the right line.
- Binned, with a mid-range exposure. This separates the two-shift-per-line order from the plain order and checks the halved line count used by the shutter.
- With zero exposure and a start pulse in mid-frame. This shows that draining covers every line and that the extra start creates no extra request.

A final frame uses an exposure equal to the line count, which is the clamp boundary. Every request, its mode, its binning flag and the drain level at each line request are matched in order against a predicted sequence. The guard time is measured on both sides of the burst.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CLEAN_REQ,
        S_CLEAN_WAIT,
        S_CLEAN_END,
        S_AB_FALL,
        S_XFER_REQ,
        S_XFER_WAIT,
        S_XFER_END,
        S_AB_RISE,
        S_SHIFT_REQ,
        S_SHIFT_WAIT,
        S_LINE_REQ,
        S_LINE_WAIT,
        S_READ_END,
        S_FRAME_END
    } fseq_state_t;

    typedef enum logic [1:0] {
        VM_NONE  = 2'b00,
        VM_BURST = 2'b01,
        VM_SHIFT = 2'b10
    } vmode_t;
endpackage

// File: rtl/seq_line_ctr.sv
module seq_line_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/seq_guard_tmr.sv
module seq_guard_tmr #(
    parameter int GUARD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);
    localparam logic [TW-1:0] LAST = TW'(GUARD_CYC - 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              tcnt <= '0;
        else if (!run)           tcnt <= '0;
        else if (tcnt != LAST)   tcnt <= tcnt + 1'b1;
    end

    assign expired = run && (tcnt == LAST);
endmodule

// File: rtl/seq_shutter.sv
module seq_shutter #(
    parameter int W = 11
) (
    input  logic [W-1:0] lines_out,
    input  logic [W-1:0] exp_lines,
    input  logic [W-1:0] line_idx,
    output logic         drain_line
);
    logic          clamp;
    logic [W-1:0]  drain_span;

    always_comb begin
        clamp      = (exp_lines >= lines_out);
        drain_span = clamp ? '0 : (lines_out - exp_lines);
        drain_line = (line_idx < drain_span);
    end
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
    import seq_pkg::*;
#(
    parameter int LINES     = 1044,
    parameter int GUARD_CYC = 100,
    parameter int EXP_W     = $clog2(LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [EXP_W-1:0] exposure,
    input  logic             bin_en,
    input  logic             clean_en,
    input  logic             vert_done,
    input  logic             line_done,
    output logic             busy,
    output logic             ab_gate,
    output logic             drain,
    output logic             vert_start,
    output logic [1:0]       vert_mode,
    output logic             line_start,
    output logic             line_bin,
    output logic             clean_done,
    output logic             xfer_done,
    output logic             read_done,
    output logic             frame_done
);
    localparam int CW = $clog2(LINES + 1);
    localparam logic [CW-1:0] FULL_N = CW'(LINES);
    localparam logic [CW-1:0] HALF_N = CW'(LINES / 2);

    fseq_state_t state_q, state_d;

    logic             bin_q, clean_q, sub_q;
    logic [EXP_W-1:0] exp_q;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    n_out;
    logic             accept, clean_last, out_last;
    logic             cnt_clr, cnt_inc;
    logic             guard_run, guard_exp;
    logic             drain_line, in_read;

    assign accept     = (state_q == S_IDLE) && start;
    assign n_out      = bin_q ? HALF_N : FULL_N;
    assign clean_last = (cnt == FULL_N - 1'b1);
    assign out_last   = (cnt == n_out - 1'b1);

    // line counter: cleaning shifts, then output lines
    assign cnt_clr = accept || (state_q == S_XFER_END);
    assign cnt_inc = ((state_q == S_CLEAN_WAIT) && vert_done && !clean_last) ||
                     ((state_q == S_LINE_WAIT)  && line_done && !out_last);

    seq_line_ctr #(.W(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    assign guard_run = (state_q == S_AB_FALL) || (state_q == S_AB_RISE);

    seq_guard_tmr #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (guard_run),
        .expired (guard_exp)
    );

    seq_shutter #(.W(CW)) u_shut (
        .lines_out  (n_out),
        .exp_lines  (CW'(exp_q)),
        .line_idx   (cnt),
        .drain_line (drain_line)
    );

    // frame settings, latched on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q   <= 1'b0;
            clean_q <= 1'b0;
            exp_q   <= '0;
        end else if (accept) begin
            bin_q   <= bin_en;
            clean_q <= clean_en;
            exp_q   <= exposure;
        end
    end

    // binning sub-shift phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sub_q <= 1'b0;
        else if (state_q == S_XFER_END)
            sub_q <= 1'b0;
        else if ((state_q == S_SHIFT_WAIT) && vert_done)
            sub_q <= bin_q && !sub_q;
        else if ((state_q == S_LINE_WAIT) && line_done)
            sub_q <= 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start) state_d = clean_en ? S_CLEAN_REQ : S_AB_FALL;
            S_CLEAN_REQ:  state_d = S_CLEAN_WAIT;
            S_CLEAN_WAIT: if (vert_done) state_d = clean_last ? S_CLEAN_END : S_CLEAN_REQ;
            S_CLEAN_END:  state_d = S_AB_FALL;
            S_AB_FALL:    if (guard_exp) state_d = S_XFER_REQ;
            S_XFER_REQ:   state_d = S_XFER_WAIT;
            S_XFER_WAIT:  if (vert_done) state_d = S_XFER_END;
            S_XFER_END:   state_d = S_AB_RISE;
            S_AB_RISE:    if (guard_exp) state_d = S_SHIFT_REQ;
            S_SHIFT_REQ:  state_d = S_SHIFT_WAIT;
            S_SHIFT_WAIT: if (vert_done) state_d = (bin_q && !sub_q) ? S_SHIFT_REQ : S_LINE_REQ;
            S_LINE_REQ:   state_d = S_LINE_WAIT;
            S_LINE_WAIT:  if (line_done) state_d = out_last ? S_READ_END : S_SHIFT_REQ;
            S_READ_END:   state_d = S_FRAME_END;
            S_FRAME_END:  state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        ab_gate    = 1'b1;
        in_read    = 1'b0;
        vert_start = 1'b0;
        vert_mode  = VM_NONE;
        line_start = 1'b0;
        clean_done = 1'b0;
        xfer_done  = 1'b0;
        read_done  = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            S_IDLE:       busy = 1'b0;
            S_CLEAN_REQ:  begin vert_start = 1'b1; vert_mode = VM_SHIFT; end
            S_CLEAN_WAIT: ;
            S_CLEAN_END:  clean_done = 1'b1;
            S_AB_FALL:    ab_gate = 1'b0;
            S_XFER_REQ:   begin ab_gate = 1'b0; vert_start = 1'b1; vert_mode = VM_BURST; end
            S_XFER_WAIT:  ab_gate = 1'b0;
            S_XFER_END:   begin ab_gate = 1'b0; xfer_done = 1'b1; end
            S_AB_RISE:    ab_gate = 1'b0;
            S_SHIFT_REQ:  begin in_read = 1'b1; vert_start = 1'b1; vert_mode = VM_SHIFT; end
            S_SHIFT_WAIT: in_read = 1'b1;
            S_LINE_REQ:   begin in_read = 1'b1; line_start = 1'b1; end
            S_LINE_WAIT:  in_read = 1'b1;
            S_READ_END:   read_done = 1'b1;
            S_FRAME_END:  frame_done = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    assign drain    = in_read && drain_line;
    assign line_bin = bin_q;

    logic unused_clean;
    assign unused_clean = clean_q;
endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk #(
    parameter int GUARD_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       ab_gate,
    input logic       drain,
    input logic       vert_start,
    input logic [1:0] vert_mode,
    input logic       line_start,
    input logic       frame_done
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_run <= '0;
        else if (ab_gate)          low_run <= '0;
        else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
    end

    AST_BURST_AB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (vert_start && vert_mode == 2'b01) |-> !ab_gate); // R3

    AST_BURST_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (vert_start && vert_mode == 2'b01) |-> (low_run >= 16'(GUARD_CYC))); // R3

    AST_NO_DRAIN_AB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_gate |-> !drain); // R7

    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9

    AST_IDLE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !busy); // R8

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R8

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vert_start |-> (vert_mode == 2'b01 || vert_mode == 2'b10)); // R10

    AST_LINE_AB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (ab_gate && busy)); // R10
endmodule

bind ccd_frame_seq ccd_frame_seq_chk #(.GUARD_CYC(GUARD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .ab_gate    (ab_gate),
    .drain      (drain),
    .vert_start (vert_start),
    .vert_mode  (vert_mode),
    .line_start (line_start),
    .frame_done (frame_done)
);

// File: tb/tb_ccd_frame_seq.sv
module tb_ccd_frame_seq;
    localparam int LINES     = 1044;
    localparam int GUARD_CYC = 100;
    localparam int EXP_W     = $clog2(LINES + 1);
    localparam int CLK_PERIOD = 10;

    localparam int K_BURST = 1, K_SHIFT = 2, K_LINE = 3, K_CDONE = 4,
                   K_XDONE = 5, K_RDONE = 6, K_FDONE = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [EXP_W-1:0] exposure = '0;
    logic             bin_en = 1'b0;
    logic             clean_en = 1'b0;
    logic             vert_done = 1'b0;
    logic             line_done = 1'b0;
    logic             busy, ab_gate, drain, vert_start, line_start, line_bin;
    logic [1:0]       vert_mode;
    logic             clean_done, xfer_done, read_done, frame_done;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    bit finished = 0;
    int expq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccd_frame_seq #(.LINES(LINES), .GUARD_CYC(GUARD_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .exposure(exposure),
        .bin_en(bin_en), .clean_en(clean_en), .vert_done(vert_done),
        .line_done(line_done), .busy(busy), .ab_gate(ab_gate), .drain(drain),
        .vert_start(vert_start), .vert_mode(vert_mode), .line_start(line_start),
        .line_bin(line_bin), .clean_done(clean_done), .xfer_done(xfer_done),
        .read_done(read_done), .frame_done(frame_done)
    );

    function automatic string req_of(input int code);
        case (code / 4)
            K_BURST: return "R2";
            K_SHIFT: return "R4/R5/R6";
            K_LINE:  return "R7";
            K_CDONE: return "R4";
            K_XDONE: return "R2";
            K_RDONE: return "R9";
            K_FDONE: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: predict a frame's event stream
    task automatic push_frame(input bit cl, input bit bn, input int e);
        int n;
        n = bn ? LINES / 2 : LINES;
        if (cl) begin
            for (int i = 0; i < LINES; i++) expq.push_back(K_SHIFT * 4);
            expq.push_back(K_CDONE * 4);
        end
        expq.push_back(K_BURST * 4);
        expq.push_back(K_XDONE * 4);
        for (int k = 0; k < n; k++) begin
            bit d;
            d = (e < n) && (k < n - e);
            expq.push_back(K_SHIFT * 4);
            if (bn) expq.push_back(K_SHIFT * 4);
            expq.push_back(K_LINE * 4 + (int'(bn) * 2) + int'(d));
        end
        expq.push_back(K_RDONE * 4);
        expq.push_back(K_FDONE * 4);
    endtask

    task automatic compare_event(input int code);
        int e;
        if (expq.size() == 0) begin
            check(0, "R8 unexpected event", code, -1);
        end else begin
            e = expq.pop_front();
            check(code == e, req_of(e), code, e);
        end
    endtask

    // responders for the two generators
    int vcnt = 0;
    int lcnt = 0;
    always @(negedge clk) begin
        vert_done = 1'b0;
        line_done = 1'b0;
        if (vcnt != 0) begin vcnt--; if (vcnt == 0) vert_done = 1'b1; end
        if (lcnt != 0) begin lcnt--; if (lcnt == 0) line_done = 1'b1; end
        if (vert_start) vcnt = 3;
        if (line_start) lcnt = 5;
    end

    // monitor
    int  low_run = 0;
    int  after_x = -1;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (clean_done) compare_event(K_CDONE * 4);
            if (vert_start && vert_mode == 2'b01) begin
                compare_event(K_BURST * 4);
                check(low_run == GUARD_CYC, "R3 guard before burst", low_run, GUARD_CYC);
            end else if (vert_start) begin
                compare_event(vert_mode == 2'b10 ? K_SHIFT * 4 : 0);
            end
            if (xfer_done) begin
                compare_event(K_XDONE * 4);
                after_x = 0;
            end else if (after_x >= 0) begin
                if (ab_gate) begin
                    check(after_x == GUARD_CYC, "R3 guard after burst", after_x, GUARD_CYC);
                    after_x = -1;
                end else after_x++;
            end
            if (line_start) begin
                compare_event(K_LINE * 4 + int'(line_bin) * 2 + int'(drain));
                if (!ab_gate) check(0, "R10 ab_gate at line", 0, 1);
            end
            if (read_done) compare_event(K_RDONE * 4);
            if (frame_done) begin
                compare_event(K_FDONE * 4);
                frames_seen++;
            end
            low_run = ab_gate ? 0 : low_run + 1;
        end
    end

    task automatic run_frame(input bit cl, input bit bn, input int e, input bit poke);
        int f0;
        push_frame(cl, bn, e);
        f0 = frames_seen;
        @(negedge clk);
        clean_en = cl; bin_en = bn; exposure = EXP_W'(e); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        if (poke) begin
            repeat (500) @(negedge clk);
            start = 1'b1;           // R8: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (frames_seen == f0) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R8 idle after frame", busy, 0);
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R9 all events seen", expq.size(), 0);
        check(busy == 1'b0 && ab_gate == 1'b1, "R8 no extra frame", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy", busy, 0);
        check(ab_gate == 1, "R1 ab_gate", ab_gate, 1);
        check(drain == 0, "R1 drain", drain, 0);
        check(!vert_start && !line_start, "R1 requests", vert_start, 0);
        check(!clean_done && !xfer_done && !read_done && !frame_done, "R1 done pulses",
              frame_done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_frame(0, 0, 2000, 0);   // R2 R5, clamp R7
        run_frame(1, 0, 10, 0);     // R4, R7 short exposure
        run_frame(0, 1, 100, 0);    // R6 binning with R7
        run_frame(0, 0, 0, 1);      // R7 full drain, R8 ignored start
        run_frame(0, 0, LINES, 0);  // R7 clamp boundary
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", frames_seen, 5);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule